// File: doc/BRIEF.md
# Prefix-Coded Call Depth Counter

This block holds a small nesting-depth field whose counter width is not fixed. Starting at the most significant bit, a run of ones followed by a single zero acts as a header. Only the bits below that zero count. A short header therefore leaves a wide counter, and a long header leaves a narrow one. A header of six ones leaves a counter of zero width. A field of all ones switches tracking off.

A call sequencer uses it as follows. It loads the field when it enters a context. It pulses the increment strobe on every call and the decrement strobe on every return. It reads back the updated field, an overflow pulse, an underflow pulse and a zero flag. The zero flag tells the sequencer whether the current nesting level is empty. The enable input gates all counting.

The field width is a parameter. The default is 7 bits.

Top module: `cdd_depth_counter`

## Requirements
- R1: After reset the field is 0x00, both error pulses are low and the zero flag is high.
- R2: When the load input is high at a clock edge, the field takes the load value on that edge. Any strobes in the same cycle are ignored and neither error pulse is raised.
- R3: An increment whose count bits are not all ones adds one to the field. No error pulse is raised. The count bits are the bits strictly below the highest zero bit. For example, 0x45 becomes 0x46 and 0x7C becomes 0x7D.
- R4: An increment whose count bits are all ones (or empty) leaves the field unchanged and raises the overflow output for one cycle. Examples are 0x3F, 0x5F, 0x7D and 0x7E.
- R5: A decrement whose count bits are not all zero subtracts one from the field. No error pulse is raised. For example, 0x46 becomes 0x45 and 0x7D becomes 0x7C.
- R6: A decrement whose count bits are all zero (or empty) leaves the field unchanged and raises the underflow output for one cycle. Examples are 0x00, 0x40 and 0x7E.
- R7: While the field is all ones (0x7F), increments and decrements change nothing and raise no error pulse.
- R8: The zero output is high exactly when the count bits are all zero or the field is all ones. It is high for 0x40 and 0x7E and low for 0x41 and 0x20.
- R9: While the enable input is low, the increment and decrement strobes have no effect on the field or on the error pulses.
- R10: When increment and decrement are asserted together, the field is unchanged and no error pulse is raised.
- R11: An error pulse lasts a single cycle. It is low after a following cycle that has no faulting strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Counting enable |
| inc_i | input | 1 | Increment strobe (call) |
| dec_i | input | 1 | Decrement strobe (return) |
| ld_i | input | 1 | Load strobe |
| ld_val_i | input | FIELD_W | Value to load |
| field_o | output | FIELD_W | Current depth field |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |
| zero_o | output | 1 | Count is zero or tracking is off |

## Verification
The bench builds the block with the default width of 7. At this width every header length from zero ones to all ones can be reached with a single load. The chosen field values cover each interesting case:
- a six-bit counter (header of zero ones),
- a five-bit counter (header of one one),
- a one-bit counter,
- the zero-width counter at 0x7E, where every strobe faults,
- the disabled code.

Together these values show that the carry and borrow stop at the separator for each prefix length.

// File: rtl/cdd_pkg.sv
package cdd_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_INC  = 2'd1,
      OP_DEC  = 2'd2
   } cdd_op_e;
endpackage

// File: rtl/cdd_prefix_decode.sv
module cdd_prefix_decode #(
   parameter int FIELD_W = 7
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic [FIELD_W-1:0] cnt_mask_o,
   output logic               all_ones_o
);
   // run[i]   : bits FIELD_W-1 .. i are all ones
   // above[i] : the separator zero sits at position i or higher
   logic [FIELD_W:0] run;
   logic [FIELD_W:0] above;

   assign run[FIELD_W]   = 1'b1;
   assign above[FIELD_W] = 1'b0;

   for (genvar i = FIELD_W - 1; i >= 0; i--) begin : g_bit
      assign run[i]        = run[i+1] & field_i[i];
      assign above[i]      = above[i+1] | (run[i+1] & ~field_i[i]);
      assign cnt_mask_o[i] = above[i+1];
   end

   assign all_ones_o = run[0];
endmodule

// File: rtl/cdd_step.sv
module cdd_step
   import cdd_pkg::*;
#(
   parameter int FIELD_W = 7
) (
   input  logic [FIELD_W-1:0] field_i,
   input  logic [FIELD_W-1:0] cnt_mask_i,
   input  logic               all_ones_i,
   input  cdd_op_e            op_i,
   output logic [FIELD_W-1:0] next_o,
   output logic               ovf_o,
   output logic               unf_o
);
   logic [FIELD_W-1:0] cnt;
   assign cnt = field_i & cnt_mask_i;

   always_comb begin
      next_o = field_i;
      ovf_o  = 1'b0;
      unf_o  = 1'b0;
      if (!all_ones_i) begin
         unique case (op_i)
            OP_INC: begin
               if (cnt == cnt_mask_i) ovf_o  = 1'b1;
               else                   next_o = field_i + FIELD_W'(1);
            end
            OP_DEC: begin
               if (cnt == '0) unf_o  = 1'b1;
               else           next_o = field_i - FIELD_W'(1);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cdd_depth_counter.sv
module cdd_depth_counter
   import cdd_pkg::*;
#(
   parameter int FIELD_W = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               inc_i,
   input  logic               dec_i,
   input  logic               ld_i,
   input  logic [FIELD_W-1:0] ld_val_i,
   output logic [FIELD_W-1:0] field_o,
   output logic               ovf_o,
   output logic               unf_o,
   output logic               zero_o
);
   if (FIELD_W < 2 || FIELD_W > 32) begin : g_bad_width
      $error("cdd_depth_counter: FIELD_W must lie in 2..32");
   end

   logic [FIELD_W-1:0] field_q;
   logic [FIELD_W-1:0] cnt_mask;
   logic               all_ones;
   logic [FIELD_W-1:0] field_nx;
   logic               ovf_nx;
   logic               unf_nx;
   cdd_op_e            op;

   cdd_prefix_decode #(.FIELD_W(FIELD_W)) u_dec (
      .field_i    (field_q),
      .cnt_mask_o (cnt_mask),
      .all_ones_o (all_ones)
   );

   always_comb begin
      op = OP_NONE;
      if (en_i && !ld_i && (inc_i ^ dec_i)) op = inc_i ? OP_INC : OP_DEC;
   end

   cdd_step #(.FIELD_W(FIELD_W)) u_step (
      .field_i    (field_q),
      .cnt_mask_i (cnt_mask),
      .all_ones_i (all_ones),
      .op_i       (op),
      .next_o     (field_nx),
      .ovf_o      (ovf_nx),
      .unf_o      (unf_nx)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         field_q <= '0;
         ovf_o   <= 1'b0;
         unf_o   <= 1'b0;
      end else begin
         field_q <= ld_i ? ld_val_i : field_nx;
         ovf_o   <= ovf_nx;
         unf_o   <= unf_nx;
      end
   end

   assign field_o = field_q;
   assign zero_o  = all_ones || ((field_q & cnt_mask) == '0);
endmodule

// File: rtl/cdd_depth_counter_chk.sv
module cdd_depth_counter_chk #(
   parameter int FIELD_W = 7
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               en_i,
   input logic               inc_i,
   input logic               dec_i,
   input logic               ld_i,
   input logic [FIELD_W-1:0] ld_val_i,
   input logic [FIELD_W-1:0] field_o,
   input logic               ovf_o,
   input logic               unf_o,
   input logic               zero_o
);
   p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(ld_i) |-> (field_o == $past(ld_val_i)) && !ovf_o && !unf_o);

   p_hold_on_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> $stable(field_o));

   p_hold_on_unf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unf_o |-> $stable(field_o));

   p_off_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(&field_o) && !$past(ld_i)) |-> (&field_o) && !ovf_o && !unf_o);

   p_zero_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&field_o) |-> zero_o);

   p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!en_i && !ld_i) |-> $stable(field_o) && !ovf_o && !unf_o);

   p_both_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(inc_i && dec_i && !ld_i) |-> $stable(field_o) && !ovf_o && !unf_o);

   p_ovf_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> $past(en_i && inc_i && !dec_i && !ld_i));

   p_unf_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unf_o |-> $past(en_i && dec_i && !inc_i && !ld_i));

   p_flags_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ovf_o && unf_o));
endmodule

bind cdd_depth_counter cdd_depth_counter_chk #(.FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/tb_cdd_depth_counter.sv
module tb_cdd_depth_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, inc = 1'b0, dec = 1'b0, ld = 1'b0;
   logic [6:0] ld_val = '0;
   logic [6:0] field;
   logic       ovf, unf, zero;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   cdd_depth_counter #(.FIELD_W(7)) dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .inc_i(inc), .dec_i(dec),
      .ld_i(ld), .ld_val_i(ld_val), .field_o(field), .ovf_o(ovf),
      .unf_o(unf), .zero_o(zero)
   );

   task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // drive one cycle of inputs, then sample just after the edge
   task automatic cyc(input logic l, input logic [6:0] v, input logic e,
                      input logic i, input logic d);
      @(negedge clk);
      ld = l; ld_val = v; en = e; inc = i; dec = d;
      @(posedge clk);
      #2;
      ld = 1'b0; inc = 1'b0; dec = 1'b0;
   endtask

   task automatic load(input logic [6:0] v);
      cyc(1'b1, v, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic expect_all(input string tag, input logic [6:0] f,
                             input logic o, input logic u);
      chk({tag, " field"}, field, f);
      chk({tag, " ovf"}, {6'd0, ovf}, {6'd0, o});
      chk({tag, " unf"}, {6'd0, unf}, {6'd0, u});
   endtask

   task automatic t_reset;
      expect_all("R1 reset", 7'h00, 1'b0, 1'b0);
      chk("R1 zero after reset", {6'd0, zero}, 7'd1);
   endtask

   task automatic t_load;
      cyc(1'b1, 7'h45, 1'b1, 1'b1, 1'b0);
      expect_all("R2 load beats inc", 7'h45, 1'b0, 1'b0);
      cyc(1'b1, 7'h40, 1'b1, 1'b0, 1'b1);
      expect_all("R2 load beats dec", 7'h40, 1'b0, 1'b0);
   endtask

   task automatic t_inc;
      load(7'h45); cyc(1'b0, 7'h0, 1'b1, 1'b1, 1'b0);
      expect_all("R3 inc 45", 7'h46, 1'b0, 1'b0);
      load(7'h00); cyc(1'b0, 7'h0, 1'b1, 1'b1, 1'b0);
      expect_all("R3 inc 00", 7'h01, 1'b0, 1'b0);
      load(7'h7C); cyc(1'b0, 7'h0, 1'b1, 1'b1, 1'b0);
      expect_all("R3 inc 7C", 7'h7D, 1'b0, 1'b0);
   endtask

   task automatic t_ovf;
      logic [6:0] vals [4] = '{7'h3F, 7'h5F, 7'h7D, 7'h7E};
      foreach (vals[k]) begin
         load(vals[k]); cyc(1'b0, 7'h0, 1'b1, 1'b1, 1'b0);
         expect_all("R4 overflow", vals[k], 1'b1, 1'b0);
         cyc(1'b0, 7'h0, 1'b1, 1'b0, 1'b0);
         expect_all("R11 ovf pulse ends", vals[k], 1'b0, 1'b0);
      end
   endtask

   task automatic t_dec;
      load(7'h46); cyc(1'b0, 7'h0, 1'b1, 1'b0, 1'b1);
      expect_all("R5 dec 46", 7'h45, 1'b0, 1'b0);
      load(7'h7D); cyc(1'b0, 7'h0, 1'b1, 1'b0, 1'b1);
      expect_all("R5 dec 7D", 7'h7C, 1'b0, 1'b0);
   endtask

   task automatic t_unf;
      logic [6:0] vals [3] = '{7'h00, 7'h40, 7'h7E};
      foreach (vals[k]) begin
         load(vals[k]); cyc(1'b0, 7'h0, 1'b1, 1'b0, 1'b1);
         expect_all("R6 underflow", vals[k], 1'b0, 1'b1);
         cyc(1'b0, 7'h0, 1'b1, 1'b0, 1'b0);
         expect_all("R11 unf pulse ends", vals[k], 1'b0, 1'b0);
      end
   endtask

   task automatic t_off;
      load(7'h7F);
      cyc(1'b0, 7'h0, 1'b1, 1'b1, 1'b0);
      expect_all("R7 off inc", 7'h7F, 1'b0, 1'b0);
      cyc(1'b0, 7'h0, 1'b1, 1'b0, 1'b1);
      expect_all("R7 off dec", 7'h7F, 1'b0, 1'b0);
      chk("R8 zero off code", {6'd0, zero}, 7'd1);
   endtask

   task automatic t_zero;
      load(7'h40); chk("R8 zero 40", {6'd0, zero}, 7'd1);
      load(7'h41); chk("R8 zero 41", {6'd0, zero}, 7'd0);
      load(7'h7E); chk("R8 zero 7E", {6'd0, zero}, 7'd1);
      load(7'h20); chk("R8 zero 20", {6'd0, zero}, 7'd0);
   endtask

   task automatic t_enable;
      load(7'h3F); cyc(1'b0, 7'h0, 1'b0, 1'b1, 1'b0);
      expect_all("R9 disabled inc", 7'h3F, 1'b0, 1'b0);
      load(7'h00); cyc(1'b0, 7'h0, 1'b0, 1'b0, 1'b1);
      expect_all("R9 disabled dec", 7'h00, 1'b0, 1'b0);
      load(7'h45); cyc(1'b0, 7'h0, 1'b0, 1'b1, 1'b0);
      expect_all("R9 disabled inc mid", 7'h45, 1'b0, 1'b0);
   endtask

   task automatic t_both;
      load(7'h45); cyc(1'b0, 7'h0, 1'b1, 1'b1, 1'b1);
      expect_all("R10 both 45", 7'h45, 1'b0, 1'b0);
      load(7'h3F); cyc(1'b0, 7'h0, 1'b1, 1'b1, 1'b1);
      expect_all("R10 both 3F", 7'h3F, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      t_reset;
      t_load;
      t_inc;
      t_ovf;
      t_dec;
      t_unf;
      t_off;
      t_zero;
      t_enable;
      t_both;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule